// File: doc/BRIEF.md
# Double-Buffered DAC Load Front End

This block is the digital side of an 8-bit voltage-output converter. A parallel data bus fills a staging register. The staging register then fills an output register, and only the output register sets the converter code. Four active-low control lines govern the two stages: a select, a write strobe, a transfer enable and a clear. The staging register follows the bus while select and the strobe are both low. The output register follows the staging path while transfer and the strobe are both low. Each stage keeps its last value once the strobe rises.

The controls arrive asynchronously. They are brought into the single clock domain through two-flop synchronizers, and the data bus goes through the same pipeline so that it stays aligned with them. The level-sensitive latch behaviour is then emulated with clock-enabled flops. The clear line has two roles. When both stages are transparent it acts as a live zero override, and a flag shows that it is active. When the stages are latched, zeros stay in both registers after the clear is released.

A timing monitor counts clock cycles to measure low-pulse widths, data setup before a loading strobe rise, and data hold after it. The limits are given in picoseconds and converted to cycles, rounded up. The monitor raises a sticky flag with a cause code and never changes the register behaviour.

Top module: `dac_load_front`

## Requirements
- R1: While `rst` is high and after it is released with all controls idle (high), `dac_code` is 0, `zero_ovr` is 0, `viol_flag` is 0 and `viol_cause` is 0.
- R2: While `sel_n` and `wstb_n` are both low, the staging register takes `bus_in`. When `wstb_n` rises it keeps the last value taken. Loading the staging register alone does not change `dac_code`.
- R3: While `xfer_n` and `wstb_n` are both low, the output register takes the staging register value, and `dac_code` shows it.
- R4: With `sel_n`, `wstb_n` and `xfer_n` all low, `dac_code` follows `bus_in`.
- R5: When `wstb_n` is high, or when `sel_n` and `xfer_n` are both high, both registers keep their contents.
- R6: `clr_n` low clears both registers. If both stages are transparent, `dac_code` is 0 and `zero_ovr` is 1 only while `clr_n` is low; after that `dac_code` follows the bus again and `zero_ovr` returns to 0.
- R7: If `clr_n` pulses low while the stages are latched, both registers hold 0 after `clr_n` returns high, and a later transfer passes 0 to `dac_code`.
- R8: Any change on the control lines or the bus reaches `dac_code` and `zero_ovr` on the third rising clock edge after it (two synchronizer stages plus the register).
- R9: A low pulse on any control line that is shorter than `PW_MIN_PS` rounded up to whole clock cycles sets `viol_flag` with `viol_cause` = 1.
- R10: If a strobe rise loads a register (select or transfer low) and the bus has been stable for fewer than the setup cycles, the monitor sets `viol_flag` with `viol_cause` = 2. A load with stable data sets nothing.
- R11: A bus change within the hold cycles after a loading strobe rise sets `viol_flag` with `viol_cause` = 3.
- R12: `viol_flag` and `viol_cause` keep the first cause until `viol_clr` is high, and `viol_clr` takes priority over a new violation. The register behaviour is the same whether or not a violation is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select for the staging register (asynchronous) |
| wstb_n | input | 1 | Active-low write strobe shared by both stages (asynchronous) |
| xfer_n | input | 1 | Active-low transfer enable for the output register (asynchronous) |
| clr_n | input | 1 | Active-low clear / zero override (asynchronous) |
| bus_in | input | DW | Parallel data bus |
| viol_clr | input | 1 | Clears the sticky timing-violation flag |
| dac_code | output | DW | Output register code driving the converter |
| zero_ovr | output | 1 | High while the clear forces zero with both stages transparent |
| viol_flag | output | 1 | Sticky timing-violation flag |
| viol_cause | output | 2 | Cause: 0 none, 1 pulse width, 2 setup, 3 hold |

## Verification
The register pair is exercised with every combination in the control table. This includes staging-only loads, which must not reach the output; a transfer of data latched earlier, which must differ from the current bus; fully transparent follow; and the clear line in both its transparent and its latched role. Bus values change while a stage is latched, so holding can be told apart from following. A single-step bus change checks the three-edge latency. The monitor is given one short strobe, a late data change, an early data change and a clean load, so that each cause code is seen alone and is shown to stay until it is cleared.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  typedef enum logic [1:0] {
    VC_NONE  = 2'd0,
    VC_PULSE = 2'd1,
    VC_SETUP = 2'd2,
    VC_HOLD  = 2'd3
  } viol_cause_e;

  localparam int NUM_CTL = 4;
  // control vector bit order: {clr_n, xfer_n, wstb_n, sel_n}
  localparam int CTL_SEL  = 0;
  localparam int CTL_WSTB = 1;
  localparam int CTL_XFER = 2;
  localparam int CTL_CLR  = 3;
endpackage

// File: rtl/dlf_sync.sv
module dlf_sync #(
  parameter int          W       = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dlf_regs.sv
module dlf_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic          wstb_n,
  input  logic          xfer_n,
  input  logic          clr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dac_q,
  output logic          zero_ovr
);
  logic [DW-1:0] stage_q;
  logic          stage_open;
  logic          out_open;
  logic [DW-1:0] stage_next;

  assign stage_open = !sel_n && !wstb_n;
  assign out_open   = !xfer_n && !wstb_n;
  // the output stage sees the bus directly when the staging stage is open
  assign stage_next = stage_open ? din : stage_q;

  always_ff @(posedge clk) begin
    if (rst || !clr_n) begin
      stage_q <= '0;
      dac_q   <= '0;
    end else begin
      stage_q <= stage_next;
      if (out_open) dac_q <= stage_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) zero_ovr <= 1'b0;
    else     zero_ovr <= !clr_n && stage_open && out_open;
  end

  p_hold_on_strobe_high_r5: assert property (@(posedge clk) disable iff (rst)
    (wstb_n && clr_n) |=> ($stable(dac_q) && $stable(stage_q)));

  p_hold_when_unselected_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_n && xfer_n && clr_n) |=> ($stable(dac_q) && $stable(stage_q)));

  p_clear_zeroes_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr_n) |=> (dac_q == '0 && stage_q == '0));

  p_transparent_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wstb_n && !xfer_n && clr_n) |=> (dac_q == $past(din)));

  p_override_zero_r6: assert property (@(posedge clk) disable iff (rst)
    zero_ovr |-> (dac_q == '0));
endmodule

// File: rtl/dlf_tmon.sv
module dlf_tmon
  import dlf_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PW_CYC    = 23,
  parameter int SETUP_CYC = 23,
  parameter int HOLD_CYC  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               viol_clr,
  input  logic [NUM_CTL-1:0] ctl_n,
  input  logic [DW-1:0]      din,
  output logic               flag,
  output logic [1:0]         cause
);
  localparam int MAXLIM = (PW_CYC > SETUP_CYC) ? PW_CYC : SETUP_CYC;
  localparam int CW     = $clog2(MAXLIM + 2);
  localparam int HW     = $clog2(HOLD_CYC + 1) + 1;

  logic [NUM_CTL-1:0] prev_v;
  logic [NUM_CTL-1:0] short_v;

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_line
    logic [CW-1:0] low_cnt;
    logic          prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        low_cnt <= '0;
        prev    <= 1'b1;
      end else begin
        prev <= ctl_n[i];
        if (ctl_n[i])              low_cnt <= '0;
        else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
      end
    end
    assign prev_v[i]  = prev;
    assign short_v[i] = ctl_n[i] && !prev && (low_cnt < CW'(PW_CYC));
  end

  logic [DW-1:0] d_prev;
  logic [CW-1:0] stab_cnt;
  logic [HW-1:0] hold_cnt;
  logic          d_chg;
  logic          load_rise;
  logic          setup_bad;
  logic          hold_bad;
  viol_cause_e   cause_q;

  assign d_chg     = (din != d_prev);
  assign load_rise = ctl_n[CTL_WSTB] && !prev_v[CTL_WSTB] &&
                     (!prev_v[CTL_SEL] || !prev_v[CTL_XFER]);
  assign setup_bad = load_rise && (stab_cnt < CW'(SETUP_CYC));
  assign hold_bad  = (hold_cnt != '0) && d_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_prev   <= '0;
      stab_cnt <= '0;
      hold_cnt <= '0;
    end else begin
      d_prev <= din;
      if (d_chg)                  stab_cnt <= '0;
      else if (stab_cnt != '1)    stab_cnt <= stab_cnt + 1'b1;
      if (load_rise)              hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != '0)    hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || viol_clr) begin
      flag    <= 1'b0;
      cause_q <= VC_NONE;
    end else if (!flag) begin
      if (|short_v) begin
        flag    <= 1'b1;
        cause_q <= VC_PULSE;
      end else if (setup_bad) begin
        flag    <= 1'b1;
        cause_q <= VC_SETUP;
      end else if (hold_bad) begin
        flag    <= 1'b1;
        cause_q <= VC_HOLD;
      end
    end
  end

  assign cause = cause_q;

  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (flag && !viol_clr) |=> (flag && $stable(cause_q)));

  p_clear_wins_r12: assert property (@(posedge clk) disable iff (rst)
    viol_clr |=> !flag);

  p_cause_with_flag_r9: assert property (@(posedge clk) disable iff (rst)
    flag |-> (cause_q != VC_NONE));

  p_no_cause_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !flag |-> (cause_q == VC_NONE));
endmodule

// File: rtl/dac_load_front.sv
module dac_load_front
  import dlf_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CLK_PS    = 4000,
  parameter int PW_MIN_PS = 90000,
  parameter int SETUP_PS  = 90000,
  parameter int HOLD_PS   = 10000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic          wstb_n,
  input  logic          xfer_n,
  input  logic          clr_n,
  input  logic [DW-1:0] bus_in,
  input  logic          viol_clr,
  output logic [DW-1:0] dac_code,
  output logic          zero_ovr,
  output logic          viol_flag,
  output logic [1:0]    viol_cause
);
  localparam int PW_CYC    = (PW_MIN_PS + CLK_PS - 1) / CLK_PS;
  localparam int SETUP_CYC = (SETUP_PS + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_CYC  = (HOLD_PS + CLK_PS - 1) / CLK_PS;
  localparam int SW        = DW + NUM_CTL;
  localparam logic [SW-1:0] SYNC_IDLE = {{NUM_CTL{1'b1}}, {DW{1'b0}}};

  logic [SW-1:0]      raw_v;
  logic [SW-1:0]      sync_v;
  logic [NUM_CTL-1:0] ctl_s;
  logic [DW-1:0]      din_s;

  assign raw_v = {clr_n, xfer_n, wstb_n, sel_n, bus_in};

  dlf_sync #(.W(SW), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_v),
    .q   (sync_v)
  );

  assign ctl_s = sync_v[SW-1:DW];
  assign din_s = sync_v[DW-1:0];

  dlf_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (ctl_s[CTL_SEL]),
    .wstb_n   (ctl_s[CTL_WSTB]),
    .xfer_n   (ctl_s[CTL_XFER]),
    .clr_n    (ctl_s[CTL_CLR]),
    .din      (din_s),
    .dac_q    (dac_code),
    .zero_ovr (zero_ovr)
  );

  dlf_tmon #(
    .DW(DW), .PW_CYC(PW_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_tmon (
    .clk      (clk),
    .rst      (rst),
    .viol_clr (viol_clr),
    .ctl_n    (ctl_s),
    .din      (din_s),
    .flag     (viol_flag),
    .cause    (viol_cause)
  );
endmodule

// File: tb/dac_load_front_tb_top.sv
module dac_load_front_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1, wstb_n = 1'b1, xfer_n = 1'b1, clr_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic       viol_clr = 1'b0;
  logic [7:0] dac_code;
  logic       zero_ovr, viol_flag;
  logic [1:0] viol_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dac_load_front dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wstb_n(wstb_n), .xfer_n(xfer_n),
    .clr_n(clr_n), .bus_in(bus_in), .viol_clr(viol_clr),
    .dac_code(dac_code), .zero_ovr(zero_ovr),
    .viol_flag(viol_flag), .viol_cause(viol_cause)
  );

  // behavioural reference: {clr, xfer, wstb, sel, data} delayed two edges
  localparam logic [11:0] IDLE = 12'hF00;
  logic [11:0] pipe_q[$];
  int m_stage = 0, m_out = 0, m_zo = 0;

  always @(posedge clk) begin
    if (rst) begin
      pipe_q = {IDLE, IDLE};
      m_stage = 0; m_out = 0; m_zo = 0;
    end else begin
      logic [11:0] s;
      int nxt;
      pipe_q.push_back({clr_n, xfer_n, wstb_n, sel_n, bus_in});
      s = pipe_q.pop_front();
      m_zo = (!s[11] && !s[8] && !s[9] && !s[10]) ? 1 : 0;
      if (!s[11]) begin
        m_stage = 0; m_out = 0;
      end else begin
        nxt = (!s[8] && !s[9]) ? int'(s[7:0]) : m_stage;
        if (!s[10] && !s[9]) m_out = nxt;
        m_stage = nxt;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 latency, R12 unaffected by flag)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R8 dac_code vs model", int'(dac_code), m_out);
      check("R6 zero_ovr vs model", int'(zero_ovr), m_zo);
    end
  end

  task automatic apply(input logic s, input logic w, input logic x, input logic c,
                       input logic [7:0] d, input int n);
    @(negedge clk); #1;
    sel_n = s; wstb_n = w; xfer_n = x; clr_n = c; bus_in = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); #1 viol_clr = 1'b1;
    @(negedge clk); #1 viol_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset dac_code", int'(dac_code), 0);
    check("R1 reset zero_ovr", int'(zero_ovr), 0);
    check("R1 reset viol_flag", int'(viol_flag), 0);
    check("R1 reset viol_cause", int'(viol_cause), 0);
    #1 rst = 1'b0;
    apply(1, 1, 1, 1, 8'h00, 10);
    check("R1 idle after reset", int'(dac_code), 0);

    // staging only: output untouched
    apply(0, 0, 1, 1, 8'hA5, 30);
    check("R2 staging load not visible", int'(dac_code), 0);
    apply(0, 1, 1, 1, 8'hA5, 10);
    apply(1, 1, 1, 1, 8'h3C, 10);
    apply(0, 1, 1, 1, 8'hC3, 10);
    check("R5 strobe high holds", int'(dac_code), 0);

    // transfer of earlier latched staging value
    apply(1, 0, 0, 1, 8'hC3, 30);
    check("R3 transfer staged value", int'(dac_code), 8'hA5);
    apply(1, 1, 0, 1, 8'h5F, 10);
    apply(1, 1, 1, 1, 8'h5F, 10);
    check("R5 hold after transfer", int'(dac_code), 8'hA5);

    // fully transparent
    apply(0, 0, 0, 1, 8'h11, 10);
    check("R4 follow 11", int'(dac_code), 8'h11);
    apply(0, 0, 0, 1, 8'h22, 10);
    check("R4 follow 22", int'(dac_code), 8'h22);
    apply(0, 0, 0, 1, 8'hFF, 10);
    check("R4 follow FF", int'(dac_code), 8'hFF);

    // zero override while transparent
    apply(0, 0, 0, 0, 8'hFF, 10);
    check("R6 override zero", int'(dac_code), 0);
    check("R6 override flag", int'(zero_ovr), 1);
    apply(0, 0, 0, 1, 8'hFF, 10);
    check("R6 release follows", int'(dac_code), 8'hFF);
    check("R6 flag drops", int'(zero_ovr), 0);
    apply(0, 0, 0, 0, 8'h5A, 10);
    check("R6 override new bus", int'(dac_code), 0);
    apply(0, 0, 0, 1, 8'h5A, 10);
    check("R6 release new bus", int'(dac_code), 8'h5A);

    // clear while latched
    apply(1, 1, 1, 1, 8'h77, 10);
    check("R5 both deselected hold", int'(dac_code), 8'h5A);
    apply(1, 1, 1, 0, 8'h77, 10);
    check("R7 latched clear", int'(dac_code), 0);
    check("R7 no override flag", int'(zero_ovr), 0);
    apply(1, 1, 1, 1, 8'h77, 10);
    check("R7 zero persists", int'(dac_code), 0);
    apply(1, 0, 0, 1, 8'h77, 30);
    check("R7 staging was cleared", int'(dac_code), 0);
    apply(1, 1, 1, 1, 8'h77, 10);

    // latency
    apply(0, 0, 0, 1, 8'h11, 30);
    apply(0, 0, 0, 1, 8'h99, 1);
    @(negedge clk); check("R8 edge1 old", int'(dac_code), 8'h11);
    @(negedge clk); check("R8 edge2 old", int'(dac_code), 8'h11);
    @(negedge clk); check("R8 edge3 new", int'(dac_code), 8'h99);
    apply(0, 1, 0, 1, 8'h99, 30);
    apply(1, 1, 1, 1, 8'h99, 30);

    // timing monitor
    pulse_clear();
    check("R12 cleared flag", int'(viol_flag), 0);
    apply(1, 0, 1, 1, 8'h99, 3);
    apply(1, 1, 1, 1, 8'h99, 10);
    check("R9 short pulse flag", int'(viol_flag), 1);
    check("R9 short pulse cause", int'(viol_cause), 1);
    apply(1, 1, 1, 1, 8'h42, 30);
    check("R12 flag sticky", int'(viol_flag), 1);
    check("R12 cause sticky", int'(viol_cause), 1);
    pulse_clear();
    check("R12 clear flag", int'(viol_flag), 0);
    check("R12 clear cause", int'(viol_cause), 0);

    // clean load: no flag
    apply(0, 0, 1, 1, 8'h42, 30);
    apply(0, 1, 1, 1, 8'h42, 10);
    apply(1, 1, 1, 1, 8'h42, 30);
    check("R10 clean load no flag", int'(viol_flag), 0);

    // setup violation
    apply(0, 0, 1, 1, 8'h42, 30);
    apply(0, 0, 1, 1, 8'h24, 2);
    apply(0, 1, 1, 1, 8'h24, 10);
    apply(1, 1, 1, 1, 8'h24, 30);
    check("R10 setup flag", int'(viol_flag), 1);
    check("R10 setup cause", int'(viol_cause), 2);
    pulse_clear();

    // hold violation
    apply(1, 0, 0, 1, 8'h24, 30);
    apply(1, 1, 0, 1, 8'h24, 1);
    apply(1, 1, 0, 1, 8'h81, 10);
    apply(1, 1, 1, 1, 8'h81, 30);
    check("R11 hold flag", int'(viol_flag), 1);
    check("R11 hold cause", int'(viol_cause), 3);
    check("R12 output unaffected", int'(dac_code), 8'h24);
    pulse_clear();
    check("R12 final clear", int'(viol_flag), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule